// File: doc/BRIEF.md
# Multi-Raster Line Repeat Sequencer

This block stretches a short source image over a taller flat panel. It counts output scanlines and, for each one, chooses whether the display-memory source line moves forward or is shown again. The choice comes from an 8-bit pattern register. The pattern is read one bit per active output line, and the read position wraps after a programmable cycle of 5 to 8 lines. Lines are only repeated while the repeat enable is high. When the enable is low, every active line advances the source line.

At the start of a frame, a programmable number of top lines is held blank and the source line stays at zero during them. A dual panel drives its lower half from a separate scan start. For that case a lower-screen strobe reloads the pattern position from a correction register, so that the repeat phase on the lower half continues smoothly from the upper half. Software writes the correction as ((cycle − (upper lines − adjust lines)) mod cycle) − 1. The block adds one to it and wraps the result inside the cycle.

Top module: `rs_line_sequencer`

## Requirements
- R1: The cycle select `cyc_sel` picks the pattern cycle length: 0 → 5 lines, 1 → 6, 2 → 7, 3 → 8.
- R2: With `rep_en` high, an active line whose pattern bit `pattern[ptr]` is 1 advances `src_line` by one on the next clock. A 0 bit leaves `src_line` unchanged, so that source line is repeated.
- R3: The pattern position starts at bit 0 after frame start. It steps by one on every active line, whether or not `rep_en` is high, and returns to 0 after the bit at position cycle length − 1.
- R4: With `rep_en` low, every active line advances `src_line` by one, whatever the pattern holds.
- R5: After a frame start, the first `vadj` line strobes are blank lines. During them `blank` is 1, and neither `src_line` nor the pattern position moves. `blank` is 0 once they are used up.
- R6: `frame_stb` sets `src_line` and the pattern position to 0 and reloads the blank-line count from `vadj` on the next clock. It takes priority over `line_stb` and `lower_stb` in the same cycle.
- R7: When `dual_mode` is high, `lower_stb` loads the pattern position with (`corr` + 1) mod cycle length. When `dual_mode` is low, `lower_stb` has no effect.
- R8: When `lower_stb` (with `dual_mode` high) and an active `line_stb` fall in the same cycle, that line is judged with the old pattern bit. The pattern position then takes the loaded value rather than the stepped one.
- R9: `src_line` is 9 bits wide and holds at 511 instead of wrapping.
- R10: After reset, `src_line` is 0 and `blank` is 0, and the pattern position is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per output scanline |
| frame_stb | input | 1 | One-cycle pulse at frame start |
| lower_stb | input | 1 | One-cycle pulse at lower-screen start of a dual panel |
| rep_en | input | 1 | Enables pattern-driven line repeating |
| dual_mode | input | 1 | Panel is split into upper and lower halves |
| cyc_sel | input | 2 | Pattern cycle length select |
| pattern | input | 8 | Repeat pattern, bit i used at position i |
| corr | input | 3 | Lower-screen phase correction |
| vadj | input | 8 | Number of blank lines at the top |
| src_line | output | 9 | Source line counter |
| blank | output | 1 | Current line is an unused top line |

## Verification
Two pattern-position updates can fall in the same cycle: the lower-screen reload and the per-line step. The line pulse and the lower-screen pulse are driven together at several correction values and cycle lengths, sometimes right at the wrap position. The outcome is judged on later lines. The source line must first follow the old pattern bit, and the lines after that must follow the bits from the loaded phase. A frame pulse is also driven together with both of the others, to check that it overrides them.

// File: rtl/rs_seq_pkg.sv
// Package: shared definitions for the multi-raster line sequencer.
// Assumes the pattern cycle length is MIN_CYCLE plus the select code.
package rs_seq_pkg;
    localparam int MIN_CYCLE = 5;

    typedef enum logic [1:0] {
        CYC_5 = 2'd0,
        CYC_6 = 2'd1,
        CYC_7 = 2'd2,
        CYC_8 = 2'd3
    } cyc_sel_e;

    // Reduce a value below 2*len into the range 0..len-1.
    function automatic logic [3:0] wrap_once(input logic [3:0] val, input logic [3:0] len);
        return (val >= len) ? (val - len) : val;
    endfunction
endpackage

// File: rtl/rs_phase_ptr.sv
// Pattern position register. It clears on frame start and loads a
// correction phase. Otherwise it steps on each active line and wraps
// after len positions. Assumes len >= 1 and that clear wins over load,
// and load wins over step.
module rs_phase_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    input  logic [PTR_W:0]   len,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W:0] ptr_inc;

    // Next position if this line steps.
    assign ptr_inc = {1'b0, ptr} + 1'b1;

    // Update the position by priority: clear, then load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= (ptr_inc >= len) ? '0 : ptr_inc[PTR_W-1:0];
        end
    end

    // R3: a plain step always lands inside the selected cycle.
    a_r3_step_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !load) |=> ({1'b0, ptr} < $past(len)));

    // R6: a clear returns the position to 0.
    a_r6_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == '0));
endmodule

// File: rtl/rs_top_adjust.sv
// Blank-line counter for the unused top lines. It reloads from the
// adjust value on frame start and counts down one per line strobe while
// nonzero. blank is high while lines remain.
module rs_top_adjust #(
    parameter int ADJ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [ADJ_W-1:0] adj_val,
    input  logic             line,
    output logic             blank
);
    logic [ADJ_W-1:0] remain;

    // Reload on frame start; otherwise consume one blank line per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (reload) begin
            remain <= adj_val;
        end else if (line && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign blank = (remain != '0);

    // R5: once the blank lines are used up, they stay used until a reload.
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && !reload) |=> !blank);
endmodule

// File: rtl/rs_src_counter.sv
// Source line counter. It clears on frame start and otherwise adds one
// when told to, holding at all-ones instead of wrapping.
module rs_src_counter #(
    parameter int SRC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [SRC_W-1:0] count
);
    // Clear, or step with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (inc && !(&count)) begin
            count <= count + 1'b1;
        end
    end

    // R9: the counter never wraps from its maximum.
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((&count) && !clear) |=> (&count));

    // R2: outside a clear the counter moves by at most one per clock.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));
endmodule

// File: rtl/rs_line_sequencer.sv
// Multi-raster line repeat sequencer (top). For every active scanline it
// decides from a rotating pattern whether the source line advances.
// It handles the blank top lines and reloads the pattern phase at the
// start of the lower half of a dual panel. Strobes are one-cycle pulses
// in the clk domain; configuration inputs are assumed quasi-static.
module rs_line_sequencer #(
    parameter int SRC_W = 9,
    parameter int ADJ_W = 8,
    parameter int PTR_W = 3,
    parameter int SEL_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_stb,
    input  logic                   frame_stb,
    input  logic                   lower_stb,
    input  logic                   rep_en,
    input  logic                   dual_mode,
    input  logic [SEL_W-1:0]       cyc_sel,
    input  logic [(1<<PTR_W)-1:0]  pattern,
    input  logic [PTR_W-1:0]       corr,
    input  logic [ADJ_W-1:0]       vadj,
    output logic [SRC_W-1:0]       src_line,
    output logic                   blank
);
    import rs_seq_pkg::*;

    localparam int LEN_W = PTR_W + 1;

    logic [LEN_W-1:0] cyc_len;
    logic [LEN_W-1:0] corr_plus;
    logic [LEN_W-1:0] corr_wrapped;
    logic [PTR_W-1:0] ptr;
    logic             active;
    logic             advance;
    logic             lower_load;

    // Cycle length from the select code.
    assign cyc_len = LEN_W'(MIN_CYCLE) + LEN_W'(cyc_sel);

    // Lower-screen phase: correction plus one, wrapped into the cycle.
    assign corr_plus    = {1'b0, corr} + 1'b1;
    assign corr_wrapped = LEN_W'(wrap_once(4'(corr_plus), 4'(cyc_len)));

    // A line is active when it is not a blank top line and no frame start overrides it.
    assign active     = line_stb && !frame_stb && !blank;
    assign advance    = active && (!rep_en || pattern[ptr]);
    assign lower_load = lower_stb && dual_mode && !frame_stb;

    rs_phase_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (frame_stb),
        .load     (lower_load),
        .load_val (corr_wrapped[PTR_W-1:0]),
        .step     (active),
        .len      (cyc_len),
        .ptr      (ptr)
    );

    rs_top_adjust #(.ADJ_W(ADJ_W)) u_adj (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (frame_stb),
        .adj_val (vadj),
        .line    (line_stb),
        .blank   (blank)
    );

    rs_src_counter #(.SRC_W(SRC_W)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frame_stb),
        .inc   (advance),
        .count (src_line)
    );

    // R6: a frame start wins over everything and clears the source line.
    a_r6_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (src_line == '0));

    // R5: a blank top line never moves the source line.
    a_r5_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !frame_stb) |=> $stable(src_line));

    // R7: a lower strobe outside dual mode leaves the position untouched.
    a_r7_single_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (lower_stb && !dual_mode && !line_stb && !frame_stb) |=> $stable(ptr));

    // R7: a lower-screen load lands inside the cycle.
    a_r7_load_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lower_load |=> ({1'b0, ptr} < $past(cyc_len)));
endmodule

// File: tb/rs_line_sequencer_tb_top.sv
// Bench for the multi-raster line sequencer. A behavioural reference
// model is updated with the same inputs the DUT samples at each rising
// edge, and the outputs are compared at every falling edge.
module rs_line_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       frame_stb = 1'b0;
    logic       lower_stb = 1'b0;
    logic       rep_en = 1'b0;
    logic       dual_mode = 1'b0;
    logic [1:0] cyc_sel = 2'd0;
    logic [7:0] pattern = 8'h00;
    logic [2:0] corr = 3'd0;
    logic [7:0] vadj = 8'd0;
    logic [8:0] src_line;
    logic       blank;

    int total = 0;
    int bad = 0;
    int m_src = 0;
    int m_ptr = 0;
    int m_adj = 0;
    string tag = "R10";
    bit done = 0;

    always #10 clk = ~clk;

    rs_line_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_stb(frame_stb),
        .lower_stb(lower_stb), .rep_en(rep_en), .dual_mode(dual_mode),
        .cyc_sel(cyc_sel), .pattern(pattern), .corr(corr), .vadj(vadj),
        .src_line(src_line), .blank(blank)
    );

    // Reference model: next state from the inputs about to be sampled.
    task automatic model_update();
        int len = 5 + int'(cyc_sel);
        int nptr = m_ptr;
        if (!rst_n) begin
            m_src = 0; m_ptr = 0; m_adj = 0;
            return;
        end
        if (frame_stb) begin
            m_src = 0; m_ptr = 0; m_adj = int'(vadj);
            return;
        end
        if (line_stb) begin
            if (m_adj > 0) begin
                m_adj--;
            end else begin
                if ((!rep_en || pattern[m_ptr]) && m_src < 511) m_src++;
                nptr = (m_ptr + 1 >= len) ? 0 : m_ptr + 1;
            end
        end
        if (lower_stb && dual_mode) nptr = (int'(corr) + 1) % len;
        m_ptr = nptr;
    endtask

    // Compare the DUT outputs with the model.
    task automatic compare();
        total++;
        if (int'(src_line) != m_src || blank != (m_adj != 0)) begin
            bad++;
            $display("FAIL %s: src_line=%0d blank=%0d expected src_line=%0d blank=%0d",
                     tag, src_line, blank, m_src, (m_adj != 0));
        end
    endtask

    // Drive strobes for one clock, advance the model, then check at the falling edge.
    task automatic step(input logic ls, input logic fs, input logic lw);
        line_stb = ls; frame_stb = fs; lower_stb = lw;
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0);
            step(0, 0, 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        // R10: reset state
        tag = "R10";
        for (int i = 0; i < 3; i++) step(0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0);

        // R1, R2, R3: every cycle length with several patterns
        tag = "R1/R2/R3";
        rep_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cyc_sel = 2'(c);
            pattern = 8'b1011_0110;
            step(0, 1, 0);
            lines(20);
            pattern = 8'b0111_1110;
            step(0, 1, 0);
            lines(20);
        end

        // R5: blank top lines
        tag = "R5";
        vadj = 8'd5; cyc_sel = 2'd1; pattern = 8'b1101_1011;
        step(0, 1, 0);
        lines(12);
        vadj = 8'd0;

        // R4: repeat disabled, all lines advance
        tag = "R4";
        rep_en = 1'b0; pattern = 8'h00;
        step(0, 1, 0);
        lines(12);
        rep_en = 1'b1;

        // R7: lower-screen load in dual mode, ignored in single mode
        tag = "R7";
        pattern = 8'b0001_0110;
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k += 3) begin
                cyc_sel = 2'(c); corr = 3'(k + c);
                dual_mode = 1'b1;
                step(0, 1, 0);
                lines(3);
                step(0, 0, 1);
                lines(9);
                dual_mode = 1'b0;
                step(0, 0, 1);
                lines(4);
            end
        end

        // R8: lower-screen load coinciding with an active line
        tag = "R8";
        dual_mode = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k++) begin
                cyc_sel = 2'(c); corr = 3'(k); pattern = 8'b1010_0101 ^ 8'(k);
                step(0, 1, 0);
                lines(k);
                step(1, 0, 1);
                step(0, 0, 0);
                lines(8);
            end
        end

        // R6: frame start overriding line and lower strobes
        tag = "R6";
        vadj = 8'd2;
        lines(5);
        step(1, 1, 1);
        lines(4);
        step(1, 1, 0);
        lines(4);
        vadj = 8'd0;
        step(1, 1, 0);
        lines(3);

        // R9: saturation at 511
        tag = "R9";
        rep_en = 1'b0; dual_mode = 1'b0;
        step(0, 1, 0);
        lines(520);

        // Mixed random traffic across all functions
        tag = "R2/R3/R7/R8";
        rep_en = 1'b1; dual_mode = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                cyc_sel = 2'($urandom_range(0, 3));
                pattern = 8'($urandom);
                corr = 3'($urandom);
                vadj = 8'($urandom_range(0, 4));
                rep_en = 1'($urandom);
            end
            step(1'($urandom_range(0, 2) == 0), ($urandom_range(0, 150) == 0),
                 ($urandom_range(0, 40) == 0));
        end

        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: bench did not finish, expected completion");
        finish_run();
    end
endmodule